// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This combinational unit sits between an execute stage and a 32-bit data memory that is addressed by word. For each memory operation code it adds a sign-extended 16-bit displacement to a base register value, checks that the resulting byte address fits the access size, and presents the memory with a word address, per-byte write enables and write data steered into the addressed byte lanes.

For loads it takes the word that the memory returns for that word address and picks out the addressed byte or halfword. It then widens the value to 32 bits with zeros or with copies of its top bit, depending on the operation code. A misaligned halfword or word access raises a fault output, and the access then writes nothing and returns zero. Operation codes that are not memory operations leave the memory side idle.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective byte address is base_i plus offset_i sign-extended to 32 bits, modulo 2^32; mem_addr_o carries bits [31:2] of it for every operation code.
- R2: Byte lanes are little-endian: address bits [1:0] equal to k select data bits [8k+7:8k]; a halfword sits in lanes 0-1 when address bit 1 is 0 and in lanes 2-3 when it is 1.
- R3: Operation code 0x03 returns the addressed byte zero-extended to 32 bits.
- R4: Operation code 0x04 returns the addressed byte sign-extended from its bit 7.
- R5: Operation code 0x05 returns the addressed halfword zero-extended, and 0x06 returns it sign-extended from its bit 15.
- R6: Operation code 0x07 returns the whole read word.
- R7: misalign_o is 1 for halfword codes (0x05, 0x06, 0x09) when address bit 0 is 1, and for word codes (0x07, 0x0A) when address bits [1:0] are not 00; byte codes (0x03, 0x04, 0x08) never fault.
- R8: While misalign_o is 1, be_o is 0000, wdata_o is 0 and load_data_o is 0.
- R9: For an aligned store, be_o is 1<<k for a byte store (0x08) at lane k, 0011 or 1100 for a halfword store (0x09), and 1111 for a word store (0x0A); be_o is 0000 for every load.
- R10: For an aligned store, wdata_o holds the low byte, low halfword or whole word of store_data_i in the lanes marked by be_o and zero in all other lanes; wdata_o is 0 when be_o is 0000.
- R11: Any operation code outside 0x03 to 0x0A gives be_o 0000, wdata_o 0, load_data_o 0 and misalign_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Operation code |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| store_data_i | input | 32 | Source register value for stores |
| rdata_i | input | 32 | Word read from the memory at mem_addr_o |
| mem_addr_o | output | 30 | Word address |
| be_o | output | 4 | Byte write enables |
| wdata_o | output | 32 | Lane-steered write data |
| load_data_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Alignment fault |

## Verification
The alignment check and the lane steering of stores act in the same cycle, and a misaligned store must win over the write enables that its size and lane would otherwise produce. The sweep provokes this by pairing every operation code with base and offset pairs whose sum lands on all four lanes, including sums that wrap past 2^32 and negative displacements. Each cycle the enables, write data and load result are compared with values derived arithmetically from the requirements, so a store that slips through while faulting, or a load that returns data while faulting, shows up as a mismatch.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {SZ_NONE, SZ_BYTE, SZ_HALF, SZ_WORD} acc_size_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    logic      sext;
    acc_size_e size;
  } acc_ctl_t;

  localparam logic [5:0] OPC_LDB  = 6'h03;
  localparam logic [5:0] OPC_LDBS = 6'h04;
  localparam logic [5:0] OPC_LDH  = 6'h05;
  localparam logic [5:0] OPC_LDHS = 6'h06;
  localparam logic [5:0] OPC_LDW  = 6'h07;
  localparam logic [5:0] OPC_STB  = 6'h08;
  localparam logic [5:0] OPC_STH  = 6'h09;
  localparam logic [5:0] OPC_STW  = 6'h0A;

  function automatic acc_ctl_t decode_op(input logic [5:0] op);
    acc_ctl_t c;
    c = '{is_load: 1'b0, is_store: 1'b0, sext: 1'b0, size: SZ_NONE};
    case (op)
      OPC_LDB:  begin c.is_load = 1'b1; c.size = SZ_BYTE; end
      OPC_LDBS: begin c.is_load = 1'b1; c.size = SZ_BYTE; c.sext = 1'b1; end
      OPC_LDH:  begin c.is_load = 1'b1; c.size = SZ_HALF; end
      OPC_LDHS: begin c.is_load = 1'b1; c.size = SZ_HALF; c.sext = 1'b1; end
      OPC_LDW:  begin c.is_load = 1'b1; c.size = SZ_WORD; end
      OPC_STB:  begin c.is_store = 1'b1; c.size = SZ_BYTE; end
      OPC_STH:  begin c.is_store = 1'b1; c.size = SZ_HALF; end
      OPC_STW:  begin c.is_store = 1'b1; c.size = SZ_WORD; end
      default:  ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  acc_size_e         size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misalign_o
);
  logic [ADDR_W-1:0] off_ext;

  assign off_ext = {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign ea_o    = base_i + off_ext;

  always_comb begin
    unique case (size_i)
      SZ_HALF: misalign_o = ea_o[0];
      SZ_WORD: misalign_o = |ea_o[LANE_W-1:0];
      default: misalign_o = 1'b0;
    endcase
  end

  always_comb begin
    // R7
    byte_never_faults_chk: assert (!(size_i == SZ_BYTE && misalign_o));
    // R7
    no_size_no_fault_chk: assert (!(size_i == SZ_NONE && misalign_o));
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NBYTES = DATA_W / 8,
  parameter int LANE_W = $clog2(NBYTES)
) (
  input  logic              en_i,
  input  acc_size_e         size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NBYTES-1:0] be_o,
  output logic [DATA_W-1:0] wdata_o
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    logic hit_b, hit_h, hit;
    logic [7:0] src;
    assign hit_b = (size_i == SZ_BYTE) && (lane_i == LANE_W'(k));
    assign hit_h = (size_i == SZ_HALF) &&
                   (lane_i[LANE_W-1:1] == (LANE_W-1)'(k / 2));
    assign hit   = en_i && (hit_b || hit_h || (size_i == SZ_WORD));
    always_comb begin
      unique case (size_i)
        SZ_BYTE: src = data_i[7:0];
        SZ_HALF: src = data_i[8*(k%2) +: 8];
        default: src = data_i[8*k +: 8];
      endcase
    end
    assign be_o[k]          = hit;
    assign wdata_o[8*k +: 8] = hit ? src : 8'h00;
  end

  always_comb begin
    // R9
    be_shape_chk: assert ($countones(be_o) == 0 || $countones(be_o) == 1 ||
                          $countones(be_o) == 2 || $countones(be_o) == NBYTES);
    // R10
    idle_no_data_chk: assert (en_i || wdata_o == '0);
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NBYTES = DATA_W / 8,
  parameter int LANE_W = $clog2(NBYTES)
) (
  input  logic              en_i,
  input  logic              sext_i,
  input  acc_size_e         size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] result_o
);
  logic [7:0]  b_val;
  logic [15:0] h_val;

  assign b_val = rdata_i[{lane_i, 3'b000} +: 8];
  assign h_val = rdata_i[{lane_i[LANE_W-1:1], 4'b0000} +: 16];

  always_comb begin
    result_o = '0;
    if (en_i) begin
      unique case (size_i)
        SZ_BYTE: result_o = {{(DATA_W-8){sext_i & b_val[7]}}, b_val};
        SZ_HALF: result_o = {{(DATA_W-16){sext_i & h_val[15]}}, h_val};
        SZ_WORD: result_o = rdata_i;
        default: result_o = '0;
      endcase
    end
  end

  always_comb begin
    // R3
    zext_byte_chk: assert (!(en_i && size_i == SZ_BYTE && !sext_i) ||
                           result_o[DATA_W-1:8] == '0);
    // R5
    zext_half_chk: assert (!(en_i && size_i == SZ_HALF && !sext_i) ||
                           result_o[DATA_W-1:16] == '0);
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  localparam int NBYTES = DATA_W / 8,
  localparam int LANE_W = $clog2(NBYTES)
) (
  input  logic [5:0]             op_i,
  input  logic [ADDR_W-1:0]      base_i,
  input  logic [OFF_W-1:0]       offset_i,
  input  logic [DATA_W-1:0]      store_data_i,
  input  logic [DATA_W-1:0]      rdata_i,
  output logic [ADDR_W-LANE_W-1:0] mem_addr_o,
  output logic [NBYTES-1:0]      be_o,
  output logic [DATA_W-1:0]      wdata_o,
  output logic [DATA_W-1:0]      load_data_o,
  output logic                   misalign_o
);
  acc_ctl_t          ctl;
  logic [ADDR_W-1:0] ea;
  logic              fault;

  assign ctl = decode_op(op_i);

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_agen (
    .base_i    (base_i),
    .offset_i  (offset_i),
    .size_i    (ctl.size),
    .ea_o      (ea),
    .misalign_o(fault)
  );

  lsu_store_lane #(.DATA_W(DATA_W)) u_st (
    .en_i   (ctl.is_store && !fault),
    .size_i (ctl.size),
    .lane_i (ea[LANE_W-1:0]),
    .data_i (store_data_i),
    .be_o   (be_o),
    .wdata_o(wdata_o)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .en_i    (ctl.is_load && !fault),
    .sext_i  (ctl.sext),
    .size_i  (ctl.size),
    .lane_i  (ea[LANE_W-1:0]),
    .rdata_i (rdata_i),
    .result_o(load_data_o)
  );

  assign mem_addr_o = ea[ADDR_W-1:LANE_W];
  assign misalign_o = fault;

  always_comb begin
    // R8
    fault_blocks_access_chk: assert (!misalign_o ||
                                     (be_o == '0 && load_data_o == '0));
    // R11
    idle_op_quiet_chk: assert (ctl.is_load || ctl.is_store ||
                               (!misalign_o && be_o == '0 && load_data_o == '0));
    // R9
    load_no_write_chk: assert (!ctl.is_load || be_o == '0);
  end
endmodule

// File: tb/sim_lsu_align_unit.sv
module sim_lsu_align_unit;
  logic        clk = 1'b0;
  logic [5:0]  op;
  logic [31:0] base, sdata, rdata;
  logic [15:0] off;
  logic [29:0] maddr;
  logic [3:0]  be;
  logic [31:0] wdata, ldata;
  logic        mis;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lsu_align_unit u0 (
    .op_i(op), .base_i(base), .offset_i(off), .store_data_i(sdata),
    .rdata_i(rdata), .mem_addr_o(maddr), .be_o(be), .wdata_o(wdata),
    .load_data_o(ldata), .misalign_o(mis)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%02h base=%08h off=%04h act=%08h exp=%08h",
               req, op, base, off, act, exp);
    end
  endtask

  task automatic run_one(input logic [5:0] o, input logic [31:0] b,
                         input logic [15:0] f, input logic [31:0] sd,
                         input logic [31:0] rd);
    logic [31:0] ea, e_ld, e_wd, bv, hv;
    logic [3:0]  e_be;
    int sz, lane;
    bit e_mis, ld, st;
    @(posedge clk); #1;
    op = o; base = b; off = f; sdata = sd; rdata = rd;
    ea   = b + {{16{f[15]}}, f};
    lane = int'(ea[1:0]);
    ld = (o >= 6'h03 && o <= 6'h07);
    st = (o >= 6'h08 && o <= 6'h0A);
    case (o)
      6'h03, 6'h04, 6'h08: sz = 1;
      6'h05, 6'h06, 6'h09: sz = 2;
      6'h07, 6'h0A:        sz = 4;
      default:             sz = 0;
    endcase
    e_mis = (sz == 2 && ea[0]) || (sz == 4 && ea[1:0] != 2'b00);
    bv = (rd >> (8 * lane)) & 32'hFF;
    hv = (rd >> (16 * (lane / 2))) & 32'hFFFF;
    e_ld = 0;
    if (ld && !e_mis) begin
      case (o)
        6'h03: e_ld = bv;
        6'h04: e_ld = bv[7] ? (bv | 32'hFFFF_FF00) : bv;
        6'h05: e_ld = hv;
        6'h06: e_ld = hv[15] ? (hv | 32'hFFFF_0000) : hv;
        default: e_ld = rd;
      endcase
    end
    e_be = 4'b0000; e_wd = 0;
    if (st && !e_mis) begin
      if (sz == 1) begin e_be = 4'b0001 << lane; e_wd = (sd & 32'hFF) << (8 * lane); end
      else if (sz == 2) begin e_be = 4'b0011 << lane; e_wd = (sd & 32'hFFFF) << (8 * lane); end
      else begin e_be = 4'b1111; e_wd = sd; end
    end
    @(negedge clk);
    chk("R1 address", {2'b00, maddr}, {2'b00, ea[31:2]});
    if (sz == 0) begin
      chk("R11 misalign", {31'd0, mis}, 32'd0);
      chk("R11 be", {28'd0, be}, 32'd0);
      chk("R11 wdata", wdata, 32'd0);
      chk("R11 load", ldata, 32'd0);
    end else begin
      chk("R7 misalign", {31'd0, mis}, {31'd0, e_mis});
      if (e_mis) begin
        chk("R8 be", {28'd0, be}, 32'd0);
        chk("R8 wdata", wdata, 32'd0);
        chk("R8 load", ldata, 32'd0);
      end else begin
        chk(st ? "R9 be" : "R9 load be", {28'd0, be}, {28'd0, e_be});
        chk("R10 wdata", wdata, e_wd);
        case (o)
          6'h03: chk("R3 R2 load", ldata, e_ld);
          6'h04: chk("R4 R2 load", ldata, e_ld);
          6'h05, 6'h06: chk("R5 R2 load", ldata, e_ld);
          6'h07: chk("R6 load", ldata, e_ld);
          default: chk("R10 store load", ldata, 32'd0);
        endcase
      end
    end
  endtask

  initial begin
    logic [31:0] bases [3];
    logic [15:0] offs [4];
    logic [31:0] rds [2];
    bases = '{32'h1000_0000, 32'hFFFF_FFFE, 32'h0000_0003};
    offs  = '{16'h0000, 16'h0001, 16'hFFFD, 16'h7FFF};
    rds   = '{32'h8A7F_F055, 32'h12C3_4E96};
    op = 6'h00; base = 0; off = 0; sdata = 0; rdata = 0;
    @(negedge clk);
    // initial idle state with a non-memory code
    chk("R11 initial be", {28'd0, be}, 32'd0);
    chk("R11 initial misalign", {31'd0, mis}, 32'd0);
    for (int o = 0; o < 16; o++)
      for (int bi = 0; bi < 3; bi++)
        for (int fi = 0; fi < 4; fi++)
          for (int ri = 0; ri < 2; ri++)
            run_one(6'(o), bases[bi], offs[fi], ~rds[ri] ^ 32'h0F0F_00FF, rds[ri]);
    // extra lane sweep from an aligned base
    for (int o = 3; o <= 10; o++)
      for (int l = 0; l < 4; l++)
        run_one(6'(o), 32'h2000_0100, 16'(l), 32'hC3A5_9F81, 32'hF1E2_D3C4);
    // codes far outside the memory range
    run_one(6'h3F, 32'h0000_0010, 16'h0004, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_one(6'h26, 32'h0000_0011, 16'h0000, 32'h1234_5678, 32'h8765_4321);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule